// File: doc/BRIEF.md
# Multiport Repeater Forwarding Engine

This block is the data path of a small bit-serial hub. Every port has a receive carrier and a receive data line. The first enabled port whose carrier rises becomes the source. The block then sends that port's frame to every other enabled port, and a shared expansion data line carries the same stream so that more devices can be cascaded. The clock ticks once per bit time. Input and output both carry one bit per tick.

The incoming preamble and start-of-frame delimiter are not passed on. The receiver discards every bit up to and including the first pair of consecutive ones. Payload bits after that pair enter a one-bit-wide elastic buffer.

The transmitter starts at once with a newly generated alternating preamble that begins with a 1. When at least the minimum count has been sent, it emits the delimiter 10101011 and then drains the buffer. If the input preamble is long, the output preamble grows in pairs until payload is available. An output shorter than the minimum frame length is padded with an alternating jam pattern. When several carriers rise in the same bit time, the lowest-numbered enabled port wins. The other active ports are reported on a collision flag vector for logic outside the block.

Top module: `repeater_fwd`

## Requirements
- R1: When no frame is in progress and enabled ports raise carrier, the lowest-numbered of them becomes the source. From the next bit time, tx_en_o is high on every other enabled port and stays low on the source port for the whole frame.
- R2: A port whose port_en_i bit is 0 never has tx_en_o high. A carrier on a disabled port never starts a frame.
- R3: In every cycle that tx_en_o[i] is high, tx_dat_o[i] equals exp_dat_o. exp_dat_o is 0 when no frame is being sent.
- R4: Each output frame starts with an even number of alternating bits, at least PRE_BITS (56) of them, beginning with 1. The delimiter 1,0,1,0,1,0,1,1 follows, in transmit order.
- R5: Received bits up to and including the first two consecutive 1s are discarded. Every later received bit appears, in order, directly after the output delimiter.
- R6: If preamble, delimiter and payload add up to fewer than MIN_BITS (96) bits, jam bits alternating from 1 are appended until the frame is exactly MIN_BITS long. Otherwise no jam is sent.
- R7: tx_en_o on each output port is high for one unbroken run per frame. It falls in the bit time after the last payload or jam bit.
- R8: While a source is receiving, col_o[i] is high for every other enabled port whose carrier is high. col_o is 0 at all other times.
- R9: During reset and until the first carrier, tx_en_o, tx_dat_o, exp_dat_o and col_o are all 0.
- R10: A frame whose carrier ends before any consecutive 1s is sent as preamble, delimiter and jam. Its length is MIN_BITS, or longer if the preamble had to be extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-time clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | N_PORTS | Per-port enable mask |
| rx_crs_i | input | N_PORTS | Per-port receive carrier |
| rx_dat_i | input | N_PORTS | Per-port receive data bit |
| tx_en_o | output | N_PORTS | Per-port transmit enable |
| tx_dat_o | output | N_PORTS | Per-port transmit data bit |
| exp_dat_o | output | 1 | Shared expansion data stream |
| col_o | output | N_PORTS | Ports with carrier while another port is source |

## Verification
The buffer-overflow property holds only if each input frame delivers at least 8 preamble and delimiter bits before its first payload bit, so that the output header never falls more than the buffer depth behind the input. The properties also assume that the enable mask does not change while a frame is in progress. The stimulus always sends 6 or more alternating preamble bits followed by the closing ones, and it changes port_en_i only between frames. It also waits after each frame until every transmitter has gone quiet before the next carrier rises.

// File: rtl/repeater_pkg.sv
`timescale 1ns/1ps
package repeater_pkg;
  typedef enum logic [2:0] {
    TX_IDLE,
    TX_PRE,
    TX_SFD,
    TX_PAY,
    TX_JAM
  } tx_state_e;
endpackage

// File: rtl/rptr_arbiter.sv
`timescale 1ns/1ps
module rptr_arbiter #(
  parameter int N_PORTS = 4,
  localparam int IW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PORTS-1:0] crs_i,
  input  logic [N_PORTS-1:0] en_i,
  input  logic               tx_busy_i,
  output logic               start_o,
  output logic               rx_act_o,
  output logic [N_PORTS-1:0] src_oh_o,
  output logic               bit_vld_o,
  output logic [IW-1:0]      src_idx_o
);
  logic [N_PORTS-1:0] req;
  logic [IW-1:0]      win_idx;
  logic               rx_act_q;
  logic [IW-1:0]      src_q;
  logic               src_crs;

  assign req = crs_i & en_i;

  // lowest index wins
  always_comb begin
    win_idx = '0;
    for (int i = N_PORTS - 1; i >= 0; i--) begin
      if (req[i]) win_idx = IW'(i);
    end
  end

  assign start_o = !rx_act_q && !tx_busy_i && (|req);
  assign src_crs = crs_i[src_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_act_q <= 1'b0;
      src_q    <= '0;
    end else if (start_o) begin
      rx_act_q <= 1'b1;
      src_q    <= win_idx;
    end else if (rx_act_q && !src_crs) begin
      rx_act_q <= 1'b0;
    end
  end

  generate
    for (genvar g = 0; g < N_PORTS; g++) begin : g_oh
      assign src_oh_o[g] = (src_q == IW'(g));
    end
  endgenerate

  assign rx_act_o  = rx_act_q;
  assign bit_vld_o = rx_act_q && src_crs;
  assign src_idx_o = src_q;
endmodule

// File: rtl/rptr_rx.sv
`timescale 1ns/1ps
module rptr_rx (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bit_vld_i,
  input  logic bit_dat_i,
  output logic push_o,
  output logic push_dat_o
);
  logic in_data_q;
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_data_q <= 1'b0;
      prev_q    <= 1'b0;
    end else if (start_i) begin
      in_data_q <= 1'b0;
      prev_q    <= 1'b0;
    end else if (bit_vld_i && !in_data_q) begin
      prev_q <= bit_dat_i;
      if (prev_q && bit_dat_i) in_data_q <= 1'b1;
    end
  end

  assign push_o     = bit_vld_i && in_data_q;
  assign push_dat_o = bit_dat_i;
endmodule

// File: rtl/rptr_fifo.sv
`timescale 1ns/1ps
module rptr_fifo #(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          push_dat_i,
  input  logic          pop_i,
  output logic          pop_dat_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DEPTH-1:0] mem_q;
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign do_pop  = pop_i && (cnt_q != '0);
  assign do_push = push_i && (cnt_q != FULL || do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= push_dat_i;
        wr_q        <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      end
      if (do_pop) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign pop_dat_o = mem_q[rd_q];
  assign count_o   = cnt_q;
  assign full_o    = (cnt_q == FULL);
endmodule

// File: rtl/rptr_tx.sv
`timescale 1ns/1ps
module rptr_tx
  import repeater_pkg::*;
#(
  parameter int PRE_BITS = 56,
  parameter int MIN_BITS = 96,
  parameter int DEPTH    = 64,
  localparam int PW = $clog2(PRE_BITS + 1),
  localparam int BW = $clog2(MIN_BITS + 1),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rx_act_i,
  input  logic [CW-1:0] fifo_cnt_i,
  input  logic          fifo_push_i,
  input  logic          fifo_dat_i,
  output logic          pop_o,
  output logic          busy_o,
  output logic          bit_o,
  output logic          in_sfd_o,
  output logic [PW-1:0] pre_cnt_o,
  output logic [BW-1:0] frame_bits_o
);
  localparam logic [PW-1:0] PRE_MAX  = PW'(PRE_BITS);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_BITS - 1);
  localparam logic [BW-1:0] MIN_MAX  = BW'(MIN_BITS);
  localparam logic [BW-1:0] MIN_LAST = BW'(MIN_BITS - 1);

  tx_state_e     st_q;
  logic [PW-1:0] pcnt_q;
  logic          pre_ph_q;
  logic [2:0]    sidx_q;
  logic          jam_ph_q;
  logic [BW-1:0] fbits_q;
  logic          last_ok;
  logic          pay_last;
  logic          buf_any;

  assign last_ok  = (fbits_q >= MIN_LAST);
  assign pay_last = (fifo_cnt_i == CW'(1)) && !fifo_push_i;
  assign buf_any  = (fifo_cnt_i != '0) || fifo_push_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= TX_IDLE;
      pcnt_q   <= '0;
      pre_ph_q <= 1'b0;
      sidx_q   <= '0;
      jam_ph_q <= 1'b0;
      fbits_q  <= '0;
    end else begin
      if (st_q != TX_IDLE && fbits_q != MIN_MAX) fbits_q <= fbits_q + 1'b1;
      case (st_q)
        TX_IDLE: begin
          if (start_i) begin
            st_q     <= TX_PRE;
            pcnt_q   <= '0;
            pre_ph_q <= 1'b0;
            sidx_q   <= '0;
            jam_ph_q <= 1'b0;
            fbits_q  <= '0;
          end
        end
        TX_PRE: begin
          pre_ph_q <= ~pre_ph_q;
          if (pcnt_q != PRE_MAX) pcnt_q <= pcnt_q + 1'b1;
          // leave only after an even count, once payload exists or input ended
          if (pcnt_q >= PRE_LAST && pre_ph_q && (fifo_cnt_i != '0 || !rx_act_i))
            st_q <= TX_SFD;
        end
        TX_SFD: begin
          sidx_q <= sidx_q + 1'b1;
          if (sidx_q == 3'd7) begin
            if (buf_any)       st_q <= TX_PAY;
            else if (!last_ok) st_q <= TX_JAM;
            else               st_q <= TX_IDLE;
          end
        end
        TX_PAY: begin
          if (pay_last) st_q <= last_ok ? TX_IDLE : TX_JAM;
        end
        TX_JAM: begin
          jam_ph_q <= ~jam_ph_q;
          if (last_ok) st_q <= TX_IDLE;
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      TX_PRE:  bit_o = ~pre_ph_q;
      TX_SFD:  bit_o = (sidx_q == 3'd7) ? 1'b1 : ~sidx_q[0];
      TX_PAY:  bit_o = fifo_dat_i;
      TX_JAM:  bit_o = ~jam_ph_q;
      default: bit_o = 1'b0;
    endcase
  end

  assign pop_o        = (st_q == TX_PAY);
  assign busy_o       = (st_q != TX_IDLE);
  assign in_sfd_o     = (st_q == TX_SFD);
  assign pre_cnt_o    = pcnt_q;
  assign frame_bits_o = fbits_q;
endmodule

// File: rtl/repeater_fwd.sv
`timescale 1ns/1ps
module repeater_fwd #(
  parameter int N_PORTS  = 4,
  parameter int PRE_BITS = 56,
  parameter int MIN_BITS = 96,
  parameter int DEPTH    = 64,
  localparam int IW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int PW = $clog2(PRE_BITS + 1),
  localparam int BW = $clog2(MIN_BITS + 1),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PORTS-1:0] port_en_i,
  input  logic [N_PORTS-1:0] rx_crs_i,
  input  logic [N_PORTS-1:0] rx_dat_i,
  output logic [N_PORTS-1:0] tx_en_o,
  output logic [N_PORTS-1:0] tx_dat_o,
  output logic               exp_dat_o,
  output logic [N_PORTS-1:0] col_o
);
  logic               start, rx_act, bit_vld, tx_busy, tx_bit;
  logic [N_PORTS-1:0] src_oh;
  logic [IW-1:0]      src_idx;
  logic               fifo_push, fifo_push_dat, fifo_pop, fifo_dat, fifo_full;
  logic [CW-1:0]      fifo_cnt;
  logic               in_sfd;
  logic [PW-1:0]      pre_cnt;
  logic [BW-1:0]      frame_bits;

  rptr_arbiter #(.N_PORTS(N_PORTS)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .crs_i     (rx_crs_i),
    .en_i      (port_en_i),
    .tx_busy_i (tx_busy),
    .start_o   (start),
    .rx_act_o  (rx_act),
    .src_oh_o  (src_oh),
    .bit_vld_o (bit_vld),
    .src_idx_o (src_idx)
  );

  rptr_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .bit_vld_i  (bit_vld),
    .bit_dat_i  (rx_dat_i[src_idx]),
    .push_o     (fifo_push),
    .push_dat_o (fifo_push_dat)
  );

  rptr_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (fifo_push),
    .push_dat_i (fifo_push_dat),
    .pop_i      (fifo_pop),
    .pop_dat_o  (fifo_dat),
    .count_o    (fifo_cnt),
    .full_o     (fifo_full)
  );

  rptr_tx #(.PRE_BITS(PRE_BITS), .MIN_BITS(MIN_BITS), .DEPTH(DEPTH)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .rx_act_i     (rx_act),
    .fifo_cnt_i   (fifo_cnt),
    .fifo_push_i  (fifo_push),
    .fifo_dat_i   (fifo_dat),
    .pop_o        (fifo_pop),
    .busy_o       (tx_busy),
    .bit_o        (tx_bit),
    .in_sfd_o     (in_sfd),
    .pre_cnt_o    (pre_cnt),
    .frame_bits_o (frame_bits)
  );

  assign tx_en_o   = {N_PORTS{tx_busy}} & port_en_i & ~src_oh;
  assign tx_dat_o  = tx_en_o & {N_PORTS{tx_bit}};
  assign exp_dat_o = tx_busy & tx_bit;
  assign col_o     = {N_PORTS{rx_act}} & rx_crs_i & port_en_i & ~src_oh;
endmodule

// File: rtl/repeater_fwd_chk.sv
`timescale 1ns/1ps
module repeater_fwd_chk #(
  parameter int N_PORTS  = 4,
  parameter int PRE_BITS = 56,
  parameter int MIN_BITS = 96,
  localparam int PW = $clog2(PRE_BITS + 1),
  localparam int BW = $clog2(MIN_BITS + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_PORTS-1:0] port_en_i,
  input logic [N_PORTS-1:0] tx_en_o,
  input logic [N_PORTS-1:0] tx_dat_o,
  input logic               exp_dat_o,
  input logic [N_PORTS-1:0] col_o,
  input logic               rx_act,
  input logic               tx_busy,
  input logic [N_PORTS-1:0] src_oh,
  input logic               fifo_push,
  input logic               fifo_pop,
  input logic               fifo_full,
  input logic               in_sfd,
  input logic [PW-1:0]      pre_cnt,
  input logic [BW-1:0]      frame_bits
);
  p_no_echo_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy |-> ($onehot(src_oh) && ((tx_en_o & src_oh) == '0)));

  p_no_disabled_tx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o & ~port_en_i) == '0);

  generate
    for (genvar g = 0; g < N_PORTS; g++) begin : g_port
      p_mirror_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_en_o[g] |-> (tx_dat_o[g] == exp_dat_o));
    end
  endgenerate

  p_exp_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> !exp_dat_o);

  p_sfd_after_pre_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_sfd) |-> (pre_cnt >= PW'(PRE_BITS)));

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_push |-> (!fifo_full || fifo_pop));

  p_min_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_busy) |-> (frame_bits >= BW'(MIN_BITS)));

  p_col_in_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_o != '0) |-> rx_act);
endmodule

bind repeater_fwd repeater_fwd_chk #(
  .N_PORTS (N_PORTS),
  .PRE_BITS(PRE_BITS),
  .MIN_BITS(MIN_BITS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .port_en_i (port_en_i),
  .tx_en_o   (tx_en_o),
  .tx_dat_o  (tx_dat_o),
  .exp_dat_o (exp_dat_o),
  .col_o     (col_o),
  .rx_act    (rx_act),
  .tx_busy   (tx_busy),
  .src_oh    (src_oh),
  .fifo_push (fifo_push),
  .fifo_pop  (fifo_pop),
  .fifo_full (fifo_full),
  .in_sfd    (in_sfd),
  .pre_cnt   (pre_cnt),
  .frame_bits(frame_bits)
);

// File: tb/repeater_fwd_tb.sv
`timescale 1ns/1ps
module repeater_fwd_tb;
  localparam int NP = 4;
  localparam int MAXB = 512;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] en, crs, rxd;
  logic [NP-1:0] tx_en, tx_dat, col;
  logic          exp_dat;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  logic cap [NP][MAXB];
  int   clen [NP];
  int   rises [NP];
  logic [NP-1:0] pen;
  int   mism;
  bit   cap_on = 0;

  always #5 clk = ~clk;

  repeater_fwd #(.N_PORTS(NP)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .port_en_i(en),
    .rx_crs_i (crs),
    .rx_dat_i (rxd),
    .tx_en_o  (tx_en),
    .tx_dat_o (tx_dat),
    .exp_dat_o(exp_dat),
    .col_o    (col)
  );

  always @(negedge clk) begin
    if (cap_on) begin
      for (int i = 0; i < NP; i++) begin
        if (tx_en[i]) begin
          if (clen[i] < MAXB) cap[i][clen[i]] = tx_dat[i];
          clen[i]++;
          if (!pen[i]) rises[i]++;
          if (tx_dat[i] !== exp_dat) mism++;
        end
      end
      pen = tx_en;
    end
  end

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: got %0d exp %0d", tag, act, expv);
    end
  endtask

  function automatic logic payb(int seed, int b);
    return logic'(((b * 5 + seed) % 7) < 3);
  endfunction

  task automatic check_stream(int p, int npay, int seed);
    int j, k, bad, elen, jst;
    logic [7:0] sfd;
    j = -1;
    for (int m = 0; m + 1 < clen[p] && m + 1 < MAXB; m++) begin
      if (j < 0 && cap[p][m] && cap[p][m+1]) j = m;
    end
    chk("R1 active port has delimiter", int'(j >= 0), 1);
    chk("R7 single tx_en run", rises[p], 1);
    if (j >= 0) begin
      k = j - 6;
      chk("R4 preamble length even and >=56", int'(k >= 56 && (k % 2) == 0), 1);
      bad = 0;
      for (int m = 0; m < k; m++) if (cap[p][m] !== logic'((m % 2) == 0)) bad++;
      chk("R4 preamble alternates from 1", bad, 0);
      sfd = '0;
      for (int m = 0; m < 8; m++) if (k + m >= 0) sfd[7-m] = cap[p][k+m];
      chk("R4 delimiter 10101011", int'(sfd), 8'hAB);
      bad = 0;
      for (int b = 0; b < npay; b++) if (cap[p][k+8+b] !== payb(seed, b)) bad++;
      chk("R5 payload order", bad, 0);
      jst  = k + 8 + npay;
      elen = (jst < 96) ? 96 : jst;
      chk("R6 R7 frame length", clen[p], elen);
      bad = 0;
      for (int m = jst; m < clen[p] && m < MAXB; m++)
        if (cap[p][m] !== logic'(((m - jst) % 2) == 0)) bad++;
      chk("R6 jam alternates from 1", bad, 0);
    end
  endtask

  task automatic run_frame(logic [NP-1:0] cm, logic [NP-1:0] em, int pl, int npay, bit sfd, int seed);
    int w, total;
    logic b;
    logic [NP-1:0] act_exp, col_exp, col_seen;
    for (int i = 0; i < NP; i++) begin
      clen[i]  = 0;
      rises[i] = 0;
    end
    mism     = 0;
    pen      = '0;
    col_seen = '0;
    cap_on   = 1;
    @(posedge clk); #2;
    en = em;
    w = -1;
    for (int i = NP - 1; i >= 0; i--) if (cm[i] && em[i]) w = i;
    total = pl + (sfd ? 2 + npay : 0);
    for (int c = 0; c < total; c++) begin
      if (c < pl)          b = logic'((c % 2) == 0);
      else if (c < pl + 2) b = 1'b1;
      else                 b = payb(seed, c - pl - 2);
      crs = cm;
      for (int i = 0; i < NP; i++) rxd[i] = (i == w) ? b : ~b;
      if (c == 4) begin
        @(negedge clk);
        col_seen = col;
      end
      @(posedge clk); #2;
    end
    crs = '0;
    rxd = '0;
    repeat (160) @(posedge clk);
    @(negedge clk);
    cap_on = 0;
    col_exp = '0;
    act_exp = '0;
    if (w >= 0) begin
      col_exp = cm & em & ~(NP'(1) << w);
      act_exp = em & ~(NP'(1) << w);
    end
    chk("R8 collision flags", int'(col_seen), int'(col_exp));
    chk("R8 collision flags idle", int'(col), 0);
    for (int i = 0; i < NP; i++) begin
      if (act_exp[i]) check_stream(i, sfd ? npay : 0, seed);
      else if (em[i]) chk("R1 source or idle port silent", clen[i], 0);
      else chk("R2 disabled port silent", clen[i], 0);
    end
    chk("R3 expansion mirrors port data", mism, 0);
    chk("R3 expansion idle", int'(exp_dat), 0);
  endtask

  initial begin
    #1900000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %0d exp %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] ems [4];
    ems[0] = 4'hF; ems[1] = 4'hA; ems[2] = 4'h6; ems[3] = 4'h1;
    rst_n = 1'b0;
    en = '0; crs = '0; rxd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset tx_en", int'(tx_en), 0);
    chk("R9 reset exp_dat", int'(exp_dat), 0);
    chk("R9 reset col", int'(col), 0);
    rst_n = 1'b1;
    en = 4'hF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 idle tx_en", int'(tx_en), 0);
    chk("R9 idle tx_dat", int'(tx_dat), 0);

    // R1 R2 R8 sweep over carrier and enable masks
    for (int e = 0; e < 4; e++)
      for (int cmv = 1; cmv < 16; cmv++)
        run_frame(NP'(cmv), ems[e], 56, 40, 1'b1, cmv + e);

    // R6 payload lengths around the jam boundary
    for (int p = 0; p <= 36; p += 3) run_frame(4'h1, 4'hF, 56, p, 1'b1, p);
    run_frame(4'h2, 4'hF, 56, 31, 1'b1, 3);
    run_frame(4'h2, 4'hF, 56, 32, 1'b1, 4);
    run_frame(4'h2, 4'hF, 56, 33, 1'b1, 5);

    // R4 R5 input preamble lengths shorter and longer than the output header
    run_frame(4'h4, 4'hF, 6, 50, 1'b1, 11);
    run_frame(4'h4, 4'hF, 8, 50, 1'b1, 12);
    run_frame(4'h4, 4'hF, 20, 50, 1'b1, 13);
    run_frame(4'h4, 4'hF, 70, 50, 1'b1, 14);
    run_frame(4'h4, 4'hF, 90, 50, 1'b1, 15);
    run_frame(4'h8, 4'hF, 6, 200, 1'b1, 16);

    // R10 fragments with no delimiter
    run_frame(4'h1, 4'hF, 10, 0, 1'b0, 0);
    run_frame(4'h1, 4'hF, 30, 0, 1'b0, 0);
    run_frame(4'h2, 4'hF, 56, 0, 1'b0, 0);
    run_frame(4'h2, 4'hF, 80, 0, 1'b0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule